// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides the RF input clock of an integer-N synthesizer down to the comparison rate of the phase detector. It runs entirely in the input clock domain. In normal mode, a prescaler divides the input by 11 or by 10. A swallow counter holds the prescaler at modulus 11 for the first A prescaler cycles of each period. A main counter counts M+1 prescaler cycles and then closes the period. The total ratio is therefore 10·(M+1)+A input cycles. In bypass mode the prescaler and the swallow counter stay idle, and the main counter counts input cycles directly, which gives a ratio of M+1.

On the last input cycle of each period the block raises a single-cycle pulse. The settings (main count, swallow count, bypass) are sampled only on that pulse or during reset. The surrounding logic can therefore rewrite them at any time without producing a malformed period. A supported setting has M from 1 up to the top of its field and A no larger than M+1. For contiguous channel spacing, the effective ratio in normal mode should be at least 90.

Top module: `psd_divider`

## Requirements
- R1: With bypass low, the pulse `fp_o` repeats every 10·(M+1)+A input clock cycles for any supported M and A.
- R2: `fp_o` is high for exactly one input cycle per period and is never high on two consecutive cycles.
- R3: Within a normal-mode period, the prescaler runs its longer modulus (11 input cycles) for the first A prescaler cycles and its shorter modulus (10 input cycles) for the rest. It never returns to 11 before the period ends.
- R4: With bypass high, `fp_o` repeats every M+1 input cycles, and the prescaler and swallow counter hold still.
- R5: `m_i`, `a_i` and `bypass_i` are sampled only in a cycle where `fp_o` is high, or while `rst` is high. A change at any other moment leaves the running period's length unchanged and takes effect in the following period.
- R6: Synchronous reset starts a fresh period. After `rst` falls, the first `fp_o` comes exactly one full period (for the settings present during reset) later.
- R7: A = 0 gives a period of 10·(M+1), built only from modulus-10 cycles. A = M+1 gives 11·(M+1), built only from modulus-11 cycles.
- R8: With M = 511 and A = 15 in normal mode, the period is 5135 input cycles.
- R9: With bypass high and M = 1, `fp_o` toggles every other cycle, which gives a ratio of 2.
- R10: `fp_o` is low in every cycle where `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF input clock being divided |
| rst | input | 1 | Synchronous active-high reset; restarts the period |
| m_i | input | M_W (9) | Main counter setting M |
| a_i | input | A_W (4) | Swallow counter setting A |
| bypass_i | input | 1 | High selects direct divide by M+1 |
| fp_o | output | 1 | One-cycle pulse on the last cycle of each period |

## Verification
The bench builds the divider with its default parameters: a 10/11 prescaler, a 9-bit M field and a 4-bit A field. These defaults put both ends of the range within a short run. The smallest bypass ratio of 2 exposes back-to-back pulse behaviour, and the largest normal ratio of 5135 exercises the full width of both counters at once. Random legal pairs with A up to M+1 cover the crossover from modulus 11 to modulus 10 at many points in the period. Directed cases place A at 0 and at M+1, change the settings mid-period, and switch between bypass and normal mode at period boundaries.

// File: rtl/psd_pkg.sv
package psd_pkg;

    // Modulus chosen by the swallow logic for the current prescaler cycle.
    typedef enum logic {
        MOD_BASE = 1'b0,   // divide by PRE_BASE
        MOD_PLUS = 1'b1    // divide by PRE_BASE + 1
    } modsel_e;

    // Period length in input cycles for a given setting.
    function automatic logic [31:0] period_len(
        input logic        byp,
        input logic [31:0] m,
        input logic [31:0] a,
        input logic [31:0] base
    );
        if (byp) begin
            return m + 32'd1;
        end
        return base * (m + 32'd1) + a;
    endfunction

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
#(
    parameter int PRE_BASE = 10,
    localparam int CW      = $clog2(PRE_BASE + 1)
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    hold_i,     // bypass: keep the counter parked at zero
    input  modsel_e modsel_i,
    output logic    tc_o        // last input cycle of a prescaler cycle
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pre_state_t;

    pre_state_t    st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        st_d  = st_q;
        limit = (modsel_i == MOD_PLUS) ? CW'(PRE_BASE) : CW'(PRE_BASE - 1);
        tc_o  = !hold_i && (st_q.cnt == limit);
        if (rst || hold_i || tc_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R3: in the short modulus the count never reaches PRE_BASE
    a_r3_base_limit: assert property (@(posedge clk) disable iff (rst)
        (modsel_i == MOD_BASE) |-> (st_q.cnt < CW'(PRE_BASE)));

    // R4: an idle prescaler stays parked
    a_r4_pre_parked: assert property (@(posedge clk) disable iff (rst)
        hold_i && $past(hold_i) && !$past(rst) |-> (st_q.cnt == '0) && !tc_o);

endmodule

// File: rtl/psd_swallow.sv
module psd_swallow
    import psd_pkg::*;
#(
    parameter int A_W = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,     // period boundary or reset
    input  logic [A_W-1:0] load_val_i,
    input  logic           step_i,     // prescaler cycle completed
    output modsel_e        modsel_o
);

    typedef struct packed {
        logic [A_W-1:0] left;
    } sw_state_t;

    sw_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        modsel_o = (st_q.left != '0) ? MOD_PLUS : MOD_BASE;
        if (rst || load_i) begin
            st_d.left = load_val_i;
        end else if (step_i && (st_q.left != '0)) begin
            st_d.left = st_q.left - A_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R3: once the short modulus is in use it holds until the next boundary
    a_r3_no_return_to_plus: assert property (@(posedge clk) disable iff (rst)
        (modsel_o == MOD_BASE) && !load_i |=> (modsel_o == MOD_BASE));

    // R3: the swallow count only moves down between boundaries
    a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> (st_q.left <= $past(st_q.left)));

endmodule

// File: rtl/psd_main.sv
module psd_main #(
    parameter int M_W = 9
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step_i,    // one count event
    input  logic [M_W-1:0] m_lim_i,   // active M
    output logic           last_o     // final count event of the period
);

    typedef struct packed {
        logic [M_W-1:0] cnt;
    } main_state_t;

    main_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        last_o = step_i && (st_q.cnt == m_lim_i);
        if (rst || last_o) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            st_d.cnt = st_q.cnt + M_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R1: the main count never passes the active limit
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= m_lim_i);

endmodule

// File: rtl/psd_divider.sv
module psd_divider
    import psd_pkg::*;
#(
    parameter int PRE_BASE = 10,
    parameter int M_W      = 9,
    parameter int A_W      = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [M_W-1:0] m_i,
    input  logic [A_W-1:0] a_i,
    input  logic           bypass_i,
    output logic           fp_o
);

    typedef struct packed {
        logic           byp;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
    } cfg_t;

    cfg_t           cfg_d, cfg_q;
    logic           boundary;
    logic           pre_tc;
    logic           main_step;
    logic [A_W-1:0] sw_load_val;
    modsel_e        modsel;

    // Settings are captured only at a period boundary or in reset.
    always_comb begin
        cfg_d       = cfg_q;
        sw_load_val = bypass_i ? '0 : a_i;
        main_step   = cfg_q.byp ? 1'b1 : pre_tc;
        if (rst || boundary) begin
            cfg_d.byp = bypass_i;
            cfg_d.m   = m_i;
            cfg_d.a   = a_i;
        end
        fp_o = boundary && !rst;
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    psd_prescaler #(
        .PRE_BASE (PRE_BASE)
    ) u_pre (
        .clk      (clk),
        .rst      (rst),
        .hold_i   (cfg_q.byp),
        .modsel_i (modsel),
        .tc_o     (pre_tc)
    );

    psd_swallow #(
        .A_W (A_W)
    ) u_sw (
        .clk        (clk),
        .rst        (rst),
        .load_i     (boundary),
        .load_val_i (sw_load_val),
        .step_i     (pre_tc),
        .modsel_o   (modsel)
    );

    psd_main #(
        .M_W (M_W)
    ) u_main (
        .clk     (clk),
        .rst     (rst),
        .step_i  (main_step),
        .m_lim_i (cfg_q.m),
        .last_o  (boundary)
    );

    // ---------------- checks ----------------
    logic [31:0] span_q;

    always_ff @(posedge clk) begin
        if (rst || fp_o) begin
            span_q <= '0;
        end else begin
            span_q <= span_q + 32'd1;
        end
    end

    // R1 / R7 / R8: normal-mode period length
    a_r1_period_len: assert property (@(posedge clk) disable iff (rst)
        fp_o && !cfg_q.byp |->
            (span_q + 32'd1 == period_len(1'b0, 32'(cfg_q.m), 32'(cfg_q.a), 32'(PRE_BASE))));

    // R4 / R9: bypass period length
    a_r4_bypass_len: assert property (@(posedge clk) disable iff (rst)
        fp_o && cfg_q.byp |->
            (span_q + 32'd1 == period_len(1'b1, 32'(cfg_q.m), 32'd0, 32'(PRE_BASE))));

    // R4: swallow logic idle in bypass
    a_r4_swallow_idle: assert property (@(posedge clk) disable iff (rst)
        cfg_q.byp |-> (modsel == MOD_BASE) && !pre_tc);

    // R2: single-cycle pulse
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fp_o |=> !fp_o);

    // R5: settings only change at a boundary
    a_r5_cfg_held: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$past(fp_o) |-> $stable(cfg_q));

    // R10: no pulse in reset
    always_comb begin
        if (rst) begin
            a_r10_quiet_in_reset: assert (!fp_o);
        end
    end

endmodule

// File: tb/psd_divider_bench.sv
module psd_divider_bench;

    localparam int CLK_PERIOD = 10;
    localparam int M_W        = 9;
    localparam int A_W        = 4;
    localparam int WAIT_LIMIT = 6000;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [M_W-1:0] m_i = 9'd5;
    logic [A_W-1:0] a_i = 4'd3;
    logic           bypass_i = 1'b0;
    logic           fp_o;

    int checks   = 0;
    int failures = 0;
    int r2_viol  = 0;
    logic prev_fp = 1'b0;

    psd_divider u_psd_divider (
        .clk      (clk),
        .rst      (rst),
        .m_i      (m_i),
        .a_i      (a_i),
        .bypass_i (bypass_i),
        .fp_o     (fp_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int exp_ratio(input bit byp, input int m, input int a);
        if (byp) return m + 1;
        return 10 * (m + 1) + a;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2 monitor: never two consecutive pulses
    always @(negedge clk) begin
        if (!rst && fp_o && prev_fp) r2_viol++;
        prev_fp <= fp_o;
    end

    // Count negedges until fp_o is seen high (inclusive).
    task automatic wait_fp(output int n);
        n = 0;
        for (int i = 0; i < WAIT_LIMIT; i++) begin
            @(negedge clk);
            n++;
            if (fp_o) return;
        end
        n = -1;
    endtask

    // Apply settings at a boundary (caller stands on a pulse cycle) and measure.
    task automatic run_cfg(input string req, input bit byp, input int m, input int a);
        int n;
        bypass_i = byp;
        m_i      = M_W'(m);
        a_i      = A_W'(a);
        wait_fp(n);
        check(req, n, exp_ratio(byp, m, a));
    endtask

    task automatic do_reset(input bit byp, input int m, input int a, input int cycles);
        rst      = 1'b1;
        bypass_i = byp;
        m_i      = M_W'(m);
        a_i      = A_W'(a);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check("R10 fp low in reset", int'(fp_o), 0);
        end
        @(posedge clk);
        #1 rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        failures++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        int m;
        int a;
        int amax;
        void'($urandom(32'd20240611));

        // R6 / R10: reset then first period
        do_reset(1'b0, 5, 3, 3);
        wait_fp(n);
        check("R6 first period after reset", n, exp_ratio(1'b0, 5, 3));

        // R1 basic repeat
        run_cfg("R1 M=5 A=3", 1'b0, 5, 3);
        run_cfg("R1 M=9 A=7", 1'b0, 9, 7);

        // R7 corners
        run_cfg("R7 A=0 M=1", 1'b0, 1, 0);
        run_cfg("R7 A=M+1 M=1", 1'b0, 1, 2);
        run_cfg("R7 A=M+1 M=14", 1'b0, 14, 15);
        run_cfg("R7 A=0 M=40", 1'b0, 40, 0);

        // R8 maximum
        run_cfg("R8 max ratio", 1'b0, 511, 15);

        // R9 / R2 minimum bypass ratio, several periods
        run_cfg("R9 bypass M=1", 1'b1, 1, 9);
        for (int i = 0; i < 4; i++) begin
            wait_fp(n);
            check("R9 bypass M=1 repeat", n, 2);
        end

        // R4 bypass larger values and switch back
        run_cfg("R4 bypass M=511", 1'b1, 511, 3);
        run_cfg("R4 bypass M=37", 1'b1, 37, 15);
        run_cfg("R1 back to normal M=20 A=11", 1'b0, 20, 11);

        // R5 mid-period change: current period unaffected
        bypass_i = 1'b0; m_i = 9'd12; a_i = 4'd4;
        wait_fp(n);
        check("R5 setup period", n, exp_ratio(1'b0, 12, 4));
        for (int i = 0; i < 7; i++) @(negedge clk);
        bypass_i = 1'b0; m_i = 9'd30; a_i = 4'd9;
        wait_fp(n);
        check("R5 running period kept", n + 7, exp_ratio(1'b0, 12, 4));
        wait_fp(n);
        check("R5 new setting next period", n, exp_ratio(1'b0, 30, 9));
        for (int i = 0; i < 3; i++) @(negedge clk);
        bypass_i = 1'b1; m_i = 9'd6;
        wait_fp(n);
        check("R5 mode change deferred", n + 3, exp_ratio(1'b0, 30, 9));
        wait_fp(n);
        check("R5 bypass after boundary", n, exp_ratio(1'b1, 6, 0));

        // R6 reset mid-period
        for (int i = 0; i < 3; i++) @(negedge clk);
        do_reset(1'b0, 8, 6, 2);
        wait_fp(n);
        check("R6 reset mid-period", n, exp_ratio(1'b0, 8, 6));

        // R1 / R3 random legal settings
        for (int i = 0; i < 40; i++) begin
            m = 1 + int'($urandom_range(0, 79));
            if ($urandom_range(0, 9) == 0) m = 1 + int'($urandom_range(0, 510));
            amax = (m + 1 < 15) ? m + 1 : 15;
            a = int'($urandom_range(0, amax));
            if ($urandom_range(0, 5) == 0) begin
                run_cfg("R4 random bypass", 1'b1, m, a);
            end else begin
                run_cfg("R3 random normal", 1'b0, m, a);
            end
        end

        check("R2 no consecutive pulses", r2_viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule